// File: doc/BRIEF.md
# Commit-Time Register Value Checker

This block sits between two redundant copies of one program that run on separate cores. The leading copy commits its register results without waiting, and pushes each destination value into a value queue in commit order. The trailing copy may commit a result only once this block has compared it with the oldest queued leading value. Because of this asymmetry, the committed trailing register state is always known to be good and can serve as the restart point after a transient fault.

On every trailing commit attempt, the trailing result is compared with the queue head. If the values are equal, the permit output rises in the same cycle and the head entry is consumed. If they differ, the commit is refused and the program counter of the offending trailing instruction is captured. The block then enters a halted state that raises a recovery request for an exception-style handler. The handler lives outside this block. When it is done, it pulses a clear input. The block then spends one cycle emptying the queue and returns to checking.

The controller has three named states. CHECK is the normal comparing state. HALT holds the recovery request. DRAIN is the one-cycle queue flush. The transitions are:
- CHECK→HALT on a mismatch.
- HALT→DRAIN on clear.
- DRAIN→CHECK unconditionally.

All other cases hold the current state.

Top module: `regchk_top`

## Requirements
- R1: After reset the state is CHECK, the queue is empty, and commit_ok, recover_req and lead_full are all low.
- R2: The queue holds up to DEPTH leading values in push order. lead_full is high exactly when DEPTH values are held, and a push while full is dropped.
- R3: In CHECK, commit_ok is high in the same cycle that trail_valid is high, the queue is non-empty, and trail_value equals the head value. The head is consumed at that clock edge, so later checks compare against later pushes in strict order.
- R4: While the queue is empty, commit_ok stays low, the trailing commit stalls, and no fault is raised.
- R5: In CHECK, trail_valid with a non-empty queue and trail_value unequal to the head keeps commit_ok low and consumes nothing. After that edge, recover_req is high and recover_pc holds that cycle's trail_pc.
- R6: While in HALT, trailing checks are ignored: commit_ok stays low, recover_pc is unchanged and no entry is consumed.
- R7: recover_clear in HALT moves to DRAIN, where the queue is emptied and pushes are dropped. The state then returns to CHECK with an empty queue and recover_req low.
- R8: Leading pushes never wait for a check; they are accepted in CHECK and in HALT whenever the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lead_push | input | 1 | Leading copy enqueues a committed value |
| lead_value | input | DATA_W | Leading destination register value |
| lead_full | output | 1 | Queue holds DEPTH values |
| trail_valid | input | 1 | Trailing instruction requests commit |
| trail_value | input | DATA_W | Trailing destination register value |
| trail_pc | input | PC_W | PC of the trailing instruction |
| commit_ok | output | 1 | Trailing commit permitted this cycle |
| recover_req | output | 1 | Mismatch detected, recovery pending |
| recover_pc | output | PC_W | PC of the faulting trailing instruction |
| recover_clear | input | 1 | Handler finished; flush and resume |

## Verification
The commit_ok and lead_full results are combinational. They are due in the same cycle as the inputs, so the bench drives inputs at the falling edge and samples those outputs one time unit later, before the rising edge. The recover_req and recover_pc results appear one rising edge after a mismatch. The queue flush is visible two edges after a clear: one edge enters DRAIN and the next empties the queue. The bench therefore samples the recovery outputs at the falling edge that follows each rising edge. Its reference model updates at that same edge, so every expectation is for the cycle in which it is observed.

// File: rtl/regchk_pkg.sv
package regchk_pkg;
    typedef enum logic [1:0] {
        ST_CHECK = 2'd0,
        ST_HALT  = 2'd1,
        ST_DRAIN = 2'd2
    } chk_state_t;
endpackage

// File: rtl/rvq_fifo.sv
module rvq_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk) begin
                if (do_push && (wr_ptr == AW'(gi))) begin
                    mem[gi] <= push_data;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/value_match.sv
module value_match #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              same
);
    logic [DATA_W-1:0] diff_bits;

    generate
        for (genvar gb = 0; gb < DATA_W; gb++) begin : g_bit
            assign diff_bits[gb] = lhs[gb] ^ rhs[gb];
        end
    endgenerate

    assign same = ~|diff_bits;
endmodule

// File: rtl/check_ctrl.sv
module check_ctrl
    import regchk_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trail_valid,
    input  logic [PC_W-1:0] trail_pc,
    input  logic            q_empty,
    input  logic            values_eq,
    input  logic            clear,
    output chk_state_t      state,
    output logic            permit,
    output logic            consume,
    output logic            flush,
    output logic            recover,
    output logic [PC_W-1:0] fault_pc
);
    chk_state_t state_nxt;
    logic       attempt;
    logic       mismatch;

    assign attempt  = trail_valid && !q_empty;
    assign mismatch = attempt && !values_eq;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CHECK;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CHECK: if (mismatch) state_nxt = ST_HALT;
            ST_HALT:  if (clear)    state_nxt = ST_DRAIN;
            ST_DRAIN:               state_nxt = ST_CHECK;
            default:                state_nxt = ST_CHECK;
        endcase
    end

    // outputs
    always_comb begin
        permit  = 1'b0;
        consume = 1'b0;
        flush   = 1'b0;
        recover = 1'b0;
        unique case (state)
            ST_CHECK: begin
                permit  = attempt && values_eq;
                consume = attempt && values_eq;
            end
            ST_HALT:  recover = 1'b1;
            ST_DRAIN: flush   = 1'b1;
            default:  ;
        endcase
    end

    // faulting PC capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_pc <= '0;
        end else if ((state == ST_CHECK) && mismatch) begin
            fault_pc <= trail_pc;
        end
    end
endmodule

// File: rtl/regchk_top.sv
module regchk_top
    import regchk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_push,
    input  logic [DATA_W-1:0] lead_value,
    output logic              lead_full,
    input  logic              trail_valid,
    input  logic [DATA_W-1:0] trail_value,
    input  logic [PC_W-1:0]   trail_pc,
    output logic              commit_ok,
    output logic              recover_req,
    output logic [PC_W-1:0]   recover_pc,
    input  logic              recover_clear
);
    chk_state_t        st;
    logic [DATA_W-1:0] q_head;
    logic              q_empty;
    logic [CNT_W-1:0]  q_count;
    logic              q_pop;
    logic              q_flush;
    logic              heads_eq;

    rvq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (lead_push),
        .push_data (lead_value),
        .pop       (q_pop),
        .flush     (q_flush),
        .head      (q_head),
        .empty     (q_empty),
        .full      (lead_full),
        .count     (q_count)
    );

    value_match #(.DATA_W(DATA_W)) u_match (
        .lhs  (trail_value),
        .rhs  (q_head),
        .same (heads_eq)
    );

    check_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .trail_valid (trail_valid),
        .trail_pc    (trail_pc),
        .q_empty     (q_empty),
        .values_eq   (heads_eq),
        .clear       (recover_clear),
        .state       (st),
        .permit      (commit_ok),
        .consume     (q_pop),
        .flush       (q_flush),
        .recover     (recover_req),
        .fault_pc    (recover_pc)
    );
endmodule

// File: rtl/regchk_sva.sv
module regchk_sva #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trail_valid,
    input logic             commit_ok,
    input logic             recover_req,
    input logic             recover_clear,
    input logic [PC_W-1:0]  recover_pc,
    input logic             lead_full,
    input logic [CNT_W-1:0] q_count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count <= CNT_W'(DEPTH)) && (lead_full == (q_count == CNT_W'(DEPTH)))); // R2
    AST_PERMIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok |-> (trail_valid && !recover_req)); // R3
    AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0) |-> !commit_ok); // R4
    AST_HALT_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (recover_req && !recover_clear) |=> (recover_req && $stable(recover_pc))); // R6
    AST_HALT_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        recover_req |-> !commit_ok); // R6
    AST_CLEAR_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (recover_req && recover_clear) |=> ##1 ((q_count == '0) && !recover_req)); // R7
endmodule

bind regchk_top regchk_sva #(.PC_W(PC_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .trail_valid   (trail_valid),
    .commit_ok     (commit_ok),
    .recover_req   (recover_req),
    .recover_clear (recover_clear),
    .recover_pc    (recover_pc),
    .lead_full     (lead_full),
    .q_count       (q_count)
);

// File: tb/regchk_top_tb_top.sv
module regchk_top_tb_top;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int PC_W   = 32;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lead_push = 1'b0;
    logic [DATA_W-1:0] lead_value = '0;
    logic              lead_full;
    logic              trail_valid = 1'b0;
    logic [DATA_W-1:0] trail_value = '0;
    logic [PC_W-1:0]   trail_pc = '0;
    logic              commit_ok;
    logic              recover_req;
    logic [PC_W-1:0]   recover_pc;
    logic              recover_clear = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model
    logic [DATA_W-1:0] mq [$];
    bit                m_halt  = 1'b0;
    bit                m_drain = 1'b0;
    logic [PC_W-1:0]   m_pc    = '0;

    always #(CLK_P/2) clk = ~clk;

    regchk_top #(.DATA_W(DATA_W), .PC_W(PC_W), .DEPTH(DEPTH)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .lead_push     (lead_push),
        .lead_value    (lead_value),
        .lead_full     (lead_full),
        .trail_valid   (trail_valid),
        .trail_value   (trail_value),
        .trail_pc      (trail_pc),
        .commit_ok     (commit_ok),
        .recover_req   (recover_req),
        .recover_pc    (recover_pc),
        .recover_clear (recover_clear)
    );

    function automatic bit exp_permit(bit tv, logic [DATA_W-1:0] tval);
        return !m_halt && !m_drain && tv && (mq.size() > 0) && (mq[0] == tval);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic step(bit push, logic [DATA_W-1:0] pval, bit tv,
                        logic [DATA_W-1:0] tval, logic [PC_W-1:0] tpc,
                        bit clr, string req);
        bit ep;
        bit ef;
        int sz;
        lead_push     = push;
        lead_value    = pval;
        trail_valid   = tv;
        trail_value   = tval;
        trail_pc      = tpc;
        recover_clear = clr;
        #1;
        ep = exp_permit(tv, tval);
        ef = (mq.size() == DEPTH);
        check(commit_ok == ep, req, "commit_ok", commit_ok, ep);
        check(lead_full == ef, "R2", "lead_full", lead_full, ef);
        @(posedge clk);
        sz = mq.size();
        if (m_drain) begin
            mq.delete();
            m_drain = 1'b0;
        end else begin
            if (m_halt) begin
                if (clr) begin
                    m_halt  = 1'b0;
                    m_drain = 1'b1;
                end
            end else if (tv && sz > 0) begin
                if (mq[0] == tval) void'(mq.pop_front());
                else begin
                    m_halt = 1'b1;
                    m_pc   = tpc;
                end
            end
            if (push && sz < DEPTH) mq.push_back(pval);
        end
        @(negedge clk);
        check(recover_req == m_halt, req, "recover_req", recover_req, m_halt);
        if (m_halt) check(recover_pc == m_pc, req, "recover_pc", recover_pc, m_pc);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(commit_ok == 1'b0, "R1", "commit_ok", commit_ok, 0);
        check(recover_req == 1'b0, "R1", "recover_req", recover_req, 0);
        check(lead_full == 1'b0, "R1", "lead_full", lead_full, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: trailing request with empty queue stalls
        step(0, 0, 1, 32'h0, 32'h10, 0, "R4");
        step(0, 0, 1, 32'h5, 32'h14, 0, "R4");
        // R2: fill to full, then an extra push is dropped
        for (int i = 0; i < DEPTH; i++) step(1, 32'h100 + i, 0, 0, 0, 0, "R2");
        step(1, 32'h999, 0, 0, 0, 0, "R2");
        check(lead_full == 1'b1, "R2", "lead_full after fill", lead_full, 1);
        // R3: ordered matching consumes the head
        step(0, 0, 1, 32'h100, 32'h20, 0, "R3");
        step(0, 0, 1, 32'h101, 32'h24, 0, "R3");
        step(1, 32'h777, 1, 32'h102, 32'h28, 0, "R3");
        // R5: mismatch latches the PC
        step(0, 0, 1, 32'hdead, 32'h40, 0, "R5");
        check(recover_pc == 32'h40, "R5", "recover_pc", recover_pc, 32'h40);
        // R6: checks ignored while halted; R8: pushes still accepted
        step(0, 0, 1, 32'h103, 32'h44, 0, "R6");
        step(0, 0, 1, 32'hbeef, 32'h48, 0, "R6");
        check(recover_pc == 32'h40, "R6", "recover_pc held", recover_pc, 32'h40);
        step(1, 32'h555, 0, 0, 0, 0, "R8");
        // R7: clear, drain, then empty queue
        step(0, 0, 0, 0, 0, 1, "R7");
        step(1, 32'h31, 1, 32'h103, 32'h50, 0, "R7");
        step(0, 0, 1, 32'h103, 32'h54, 0, "R7");
        check(commit_ok == 1'b0, "R7", "commit_ok after drain", commit_ok, 0);
        step(1, 32'h7, 0, 0, 0, 0, "R8");
        step(0, 0, 1, 32'h7, 32'h58, 0, "R3");
        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit p;
            bit tv;
            bit clr;
            logic [DATA_W-1:0] tval;
            string tag;
            p   = ($urandom % 2) == 0;
            tv  = ($urandom % 3) != 0;
            clr = m_halt && (($urandom % 4) == 0);
            if (mq.size() > 0 && ($urandom % 25) != 0) tval = mq[0];
            else tval = $urandom;
            if (m_halt) tag = "R6";
            else if (m_drain) tag = "R7";
            else if (tv && mq.size() == 0) tag = "R4";
            else if (tv && mq[0] != tval) tag = "R5";
            else tag = "R3";
            step(p, $urandom, tv, tval, $urandom, clr, tag);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule